// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block keeps the interrupt-pending state for the two channels of a disk controller and drives the single level-sensitive interrupt line the controller presents to its host bus. Each channel's pending flag is visible in two configuration bytes: a per-channel legacy status byte and a shared mode byte that also carries the per-channel block (mask) flags. Whichever copy changes, the other follows in the same clock, so software may poll or acknowledge through either view.

The drive side supplies one interrupt level per channel. A change of that level is an event: the new level becomes the pending flag in both copies. Software clears a pending flag by writing a one to it through the configuration write port. A write can never set a pending flag or alter any other bit of these bytes. A separate mask write port loads the two block flags. The interrupt line is high while any channel is pending and not blocked. It is registered and follows its cause by one clock.

Top module: `irqmir_top`

## Requirements
- R1: After reset every pending flag and every block flag reads as zero and `irq_o` is low.
- R2: A rise of `drv_irq[n]` sets channel n pending in both views: byte 0x50 bit 2 for channel 0, byte 0x57 bit 4 for channel 1, and byte 0x71 bit 2 (channel 0) or bit 3 (channel 1). A level that stays high sets nothing again after it has been cleared.
- R3: A fall of `drv_irq[n]` clears channel n pending in both views.
- R4: A config write with a one at byte 0x50 bit 2 clears channel 0 in both views. A one at byte 0x57 bit 4 clears channel 1 in both views.
- R5: A config write with a one at byte 0x71 bit 2 or bit 3 clears channel 0 or channel 1 in both views. A single access that enables several byte lanes applies the rule of each byte it touches.
- R6: A config write never sets a pending flag. It never changes the block flags or any other bit of the three bytes. Zero data bits, disabled byte lanes and other byte offsets have no effect.
- R7: `mask_wr_en` loads `mask_wr_data` into the block flags, which read back at byte 0x71 bit 4 (channel 0) and bit 5 (channel 1).
- R8: `irq_o` is high when channel 0 is pending and not blocked, or when channel 1 is pending and not blocked.
- R9: `irq_o` is registered. It changes at the clock edge that samples the drive level, config write or mask write causing the change, and not before.
- R10: When a drive level change and a config clear hit the same channel in the same cycle, the drive level decides the pending flag.
- R11: Config data is little-endian within a 32-bit word: byte address A sits on lane A mod 4 of the word at A with its two low bits cleared. Reads of words holding none of the three bytes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq | input | 2 | Drive-side interrupt level per channel |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_wr_addr | input | 8 | Config byte address of the write (word aligned by the low bits) |
| cfg_wr_be | input | 4 | Byte-lane enables of the write |
| cfg_wr_data | input | 32 | Config write data |
| cfg_rd_addr | input | 8 | Config read address (word) |
| cfg_rd_data | output | 32 | Config read data for the addressed word, combinational from state |
| mask_wr_en | input | 1 | Block flag write strobe |
| mask_wr_data | input | 2 | New block flags, one per channel |
| irq_o | output | 1 | Combined level interrupt |

## Verification
Every state change is due at the first rising edge after the stimulus is applied. The pending copies, the block flags and `irq_o` all update at that one edge, and config reads then follow the state with no further delay. The bench applies stimulus one time unit after an edge and checks `irq_o` before the next edge, to show nothing moved early. It then checks the interrupt line and the read-back words one time unit after that edge. Since reads are combinational, read-back checks set the read address and wait one time unit without a clock.

// File: rtl/irqmir_pkg.sv
package irqmir_pkg;

  localparam int NCH      = 2;
  localparam int MODE_OFS = 'h71;

  // Offset of the legacy status byte of a channel
  function automatic int leg_ofs(input int ch);
    return (ch == 0) ? 'h50 : 'h57;
  endfunction

  // Pending bit inside the legacy status byte
  function automatic int leg_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  // Pending and block bits inside the shared mode byte
  function automatic int mode_pend_bit(input int ch);
    return 2 + ch;
  endfunction

  function automatic int mode_blk_bit(input int ch);
    return 4 + ch;
  endfunction

endpackage

// File: rtl/irqmir_cfg_dec.sv
module irqmir_cfg_dec
  import irqmir_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW/8-1:0]   wr_be,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH-1:0]    leg_hit,
  output logic [NCH-1:0]    leg_clr,
  output logic              mode_hit,
  output logic [NCH-1:0]    mode_clr
);

  localparam int BYTES = DW / 8;
  localparam int LW    = $clog2(BYTES);

  logic [AW-1:0] base;
  logic [AW-1:0] ba;
  logic [7:0]    bd;

  assign base = {wr_addr[AW-1:LW], {LW{1'b0}}};

  // Each enabled lane is one byte write; the lane's rules apply to its byte.
  always_comb begin
    leg_hit  = '0;
    leg_clr  = '0;
    mode_hit = 1'b0;
    mode_clr = '0;
    ba       = base;
    bd       = '0;
    for (int l = 0; l < BYTES; l++) begin
      ba = base | AW'(l);
      bd = wr_data[8*l +: 8];
      if (wr_en && wr_be[l]) begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (ba == AW'(leg_ofs(ch))) begin
            leg_hit[ch] = 1'b1;
            leg_clr[ch] = bd[leg_bit(ch)];
          end
        end
        if (ba == AW'(MODE_OFS)) begin
          mode_hit = 1'b1;
          for (int ch = 0; ch < NCH; ch++) begin
            mode_clr[ch] = bd[mode_pend_bit(ch)];
          end
        end
      end
    end
  end

endmodule

// File: rtl/irqmir_chan.sv
module irqmir_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_lvl,
  input  logic leg_hit,
  input  logic leg_clr,
  input  logic mode_hit,
  input  logic mode_clr,
  output logic leg_o,
  output logic pend_o,
  output logic pend_nxt_o
);

  logic drv_q;
  logic leg_q, leg_n;
  logic mode_q, mode_n;
  logic evt;
  logic upd_en;

  assign evt    = drv_lvl ^ drv_q;
  assign upd_en = leg_hit | mode_hit | evt;

  // Order inside one cycle: legacy byte, then mode byte, then drive event.
  always_comb begin
    leg_n  = leg_q;
    mode_n = mode_q;
    if (leg_hit) begin
      leg_n  = leg_n & ~leg_clr;
      mode_n = leg_n;
    end
    if (mode_hit) begin
      mode_n = mode_n & ~mode_clr;
      leg_n  = mode_n;
    end
    if (evt) begin
      mode_n = drv_lvl;
      leg_n  = drv_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      leg_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (evt) begin
        drv_q <= drv_lvl;
      end
      if (upd_en) begin
        leg_q  <= leg_n;
        mode_q <= mode_n;
      end
    end
  end

  assign leg_o      = leg_q;
  assign pend_o     = mode_q;
  assign pend_nxt_o = mode_n;

endmodule

// File: rtl/irqmir_combine.sv
module irqmir_combine #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_nxt,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_d,
  output logic [NCH-1:0] blk_o,
  output logic           irq_o
);

  logic [NCH-1:0] blk_q, blk_n;
  logic           irq_q, irq_n;

  always_comb begin
    blk_n = mask_we ? mask_d : blk_q;
    irq_n = |(pend_nxt & ~blk_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (mask_we) begin
        blk_q <= blk_n;
      end
      irq_q <= irq_n;
    end
  end

  assign blk_o = blk_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/irqmir_top.sv
module irqmir_top
  import irqmir_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    drv_irq,
  input  logic              cfg_wr_en,
  input  logic [AW-1:0]     cfg_wr_addr,
  input  logic [DW/8-1:0]   cfg_wr_be,
  input  logic [DW-1:0]     cfg_wr_data,
  input  logic [AW-1:0]     cfg_rd_addr,
  output logic [DW-1:0]     cfg_rd_data,
  input  logic              mask_wr_en,
  input  logic [NCH-1:0]    mask_wr_data,
  output logic              irq_o
);

  localparam int BYTES = DW / 8;
  localparam int LW    = $clog2(BYTES);

  logic [NCH-1:0] leg_hit, leg_clr, mode_clr;
  logic           mode_hit;
  logic [NCH-1:0] leg_v, pend_v, pend_nxt, blk_v;

  irqmir_cfg_dec #(.AW(AW), .DW(DW)) u_dec (
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_be    (cfg_wr_be),
    .wr_data  (cfg_wr_data),
    .leg_hit  (leg_hit),
    .leg_clr  (leg_clr),
    .mode_hit (mode_hit),
    .mode_clr (mode_clr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    irqmir_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .drv_lvl    (drv_irq[ch]),
      .leg_hit    (leg_hit[ch]),
      .leg_clr    (leg_clr[ch]),
      .mode_hit   (mode_hit),
      .mode_clr   (mode_clr[ch]),
      .leg_o      (leg_v[ch]),
      .pend_o     (pend_v[ch]),
      .pend_nxt_o (pend_nxt[ch])
    );
  end

  irqmir_combine #(.NCH(NCH)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_nxt (pend_nxt),
    .mask_we  (mask_wr_en),
    .mask_d   (mask_wr_data),
    .blk_o    (blk_v),
    .irq_o    (irq_o)
  );

  logic [AW-1:0] rbase;
  logic [AW-1:0] rba;

  assign rbase = {cfg_rd_addr[AW-1:LW], {LW{1'b0}}};

  always_comb begin
    cfg_rd_data = '0;
    rba         = rbase;
    for (int l = 0; l < BYTES; l++) begin
      rba = rbase | AW'(l);
      for (int ch = 0; ch < NCH; ch++) begin
        if (rba == AW'(leg_ofs(ch))) begin
          cfg_rd_data[8*l + leg_bit(ch)] = leg_v[ch];
        end
        if (rba == AW'(MODE_OFS)) begin
          cfg_rd_data[8*l + mode_pend_bit(ch)] = pend_v[ch];
          cfg_rd_data[8*l + mode_blk_bit(ch)]  = blk_v[ch];
        end
      end
    end
  end

endmodule

// File: rtl/irqmir_chk.sv
module irqmir_chk
  import irqmir_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    drv_irq,
  input logic              cfg_wr_en,
  input logic [AW-1:0]     cfg_wr_addr,
  input logic [DW/8-1:0]   cfg_wr_be,
  input logic [DW-1:0]     cfg_wr_data,
  input logic              mask_wr_en,
  input logic [NCH-1:0]    leg_v,
  input logic [NCH-1:0]    pend_v,
  input logic [NCH-1:0]    blk_v,
  input logic              irq_o
);

  localparam int BYTES = DW / 8;
  localparam int LW    = $clog2(BYTES);
  localparam int L0    = 'h50 % BYTES;
  localparam logic [AW-LW-1:0] W0 = (AW-LW)'('h50 >> LW);

  logic [NCH-1:0] dq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq <= '0;
    else        dq <= drv_irq;
  end

  logic clr0_legacy;
  assign clr0_legacy = cfg_wr_en && (cfg_wr_addr[AW-1:LW] == W0) &&
                       cfg_wr_be[L0] && cfg_wr_data[8*L0 + 2] &&
                       (drv_irq[0] == dq[0]);

  // R2 R3 R4 R5: the two views of each channel never disagree
  assert_copies_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    leg_v == pend_v);

  // R8: line equals pending and not blocked
  assert_irq_combine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(pend_v & ~blk_v));

  // R4: legacy acknowledge clears channel 0 when the drive is quiet
  assert_legacy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr0_legacy |=> !pend_v[0]);

  // R6: without a drive rise a clear flag stays clear
  assert_no_set_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_v[0] && !(drv_irq[0] && !dq[0])) |=> !pend_v[0]);

  assert_no_set_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_v[1] && !(drv_irq[1] && !dq[1])) |=> !pend_v[1]);

  // R7: block flags move only on a mask write
  assert_blk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> $stable(blk_v));

endmodule

bind irqmir_top irqmir_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/irqmir_top_tb.sv
module irqmir_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  drv_irq;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_addr;
  logic [3:0]  cfg_wr_be;
  logic [31:0] cfg_wr_data;
  logic [7:0]  cfg_rd_addr;
  logic [31:0] cfg_rd_data;
  logic        mask_wr_en;
  logic [1:0]  mask_wr_data;
  logic        irq_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irqmir_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .drv_irq      (drv_irq),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_be    (cfg_wr_be),
    .cfg_wr_data  (cfg_wr_data),
    .cfg_rd_addr  (cfg_rd_addr),
    .cfg_rd_data  (cfg_rd_data),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .irq_o        (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    cfg_rd_addr = a;
    #1;
    chk(req, cfg_rd_data, exp);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d; cfg_wr_be = be;
    tick();
    cfg_wr_en = 1'b0; cfg_wr_be = '0;
  endtask

  task automatic drv_set(input logic [1:0] v);
    drv_irq = v;
    tick();
  endtask

  task automatic mask_set(input logic [1:0] v);
    mask_wr_en = 1'b1; mask_wr_data = v;
    tick();
    mask_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R1 0x50", 8'h50, 32'h0);
    rd_chk("R1 0x54", 8'h54, 32'h0);
    rd_chk("R1 0x70", 8'h70, 32'h0);
    rd_chk("R11 other word", 8'h60, 32'h0);
  endtask

  task automatic t_drive_rise();
    drv_irq = 2'b01;
    #5;
    chk("R9 irq before edge", {31'b0, irq_o}, 32'h0);
    tick();
    chk("R2 irq ch0", {31'b0, irq_o}, 32'h1);
    rd_chk("R2 ch0 legacy", 8'h50, 32'h0000_0004);
    rd_chk("R2 ch0 mode", 8'h70, 32'h0000_0400);
    drv_set(2'b11);
    rd_chk("R2 ch1 legacy", 8'h54, 32'h1000_0000);
    rd_chk("R2 both mode", 8'h70, 32'h0000_0C00);
  endtask

  task automatic t_legacy_ack();
    cfg_wr(8'h50, 32'h0000_0004, 4'b0001);
    rd_chk("R4 ch0 legacy", 8'h50, 32'h0);
    rd_chk("R4 ch0 mode", 8'h70, 32'h0000_0800);
    chk("R4 irq ch1 left", {31'b0, irq_o}, 32'h1);
    cfg_wr(8'h54, 32'h1000_0000, 4'b1000);
    rd_chk("R4 ch1 legacy", 8'h54, 32'h0);
    rd_chk("R4 ch1 mode", 8'h70, 32'h0);
    chk("R4 irq low", {31'b0, irq_o}, 32'h0);
    tick();
    rd_chk("R2 steady level no reset", 8'h70, 32'h0);
  endtask

  task automatic t_drive_fall();
    drv_set(2'b00);
    drv_set(2'b11);
    rd_chk("R2 re-raise", 8'h70, 32'h0000_0C00);
    drv_set(2'b01);
    rd_chk("R3 ch1 legacy", 8'h54, 32'h0);
    rd_chk("R3 ch1 mode", 8'h70, 32'h0000_0400);
    chk("R3 irq", {31'b0, irq_o}, 32'h1);
    drv_set(2'b00);
    chk("R3 irq low", {31'b0, irq_o}, 32'h0);
    rd_chk("R3 ch0 legacy", 8'h50, 32'h0);
  endtask

  task automatic t_mode_ack();
    drv_set(2'b11);
    cfg_wr(8'h70, 32'h0000_0400, 4'b0010);
    rd_chk("R5 ch0 legacy", 8'h50, 32'h0);
    rd_chk("R5 ch1 kept", 8'h54, 32'h1000_0000);
    cfg_wr(8'h70, 32'h0000_0800, 4'b0010);
    rd_chk("R5 ch1 legacy", 8'h54, 32'h0);
    chk("R5 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_no_effect();
    drv_set(2'b00);
    drv_set(2'b11);
    cfg_wr(8'h50, 32'hFFFF_FFFB, 4'b1111);
    cfg_wr(8'h70, 32'hFFFF_F3FF, 4'b1111);
    cfg_wr(8'h50, 32'h0000_0004, 4'b1110);
    cfg_wr(8'h54, 32'h0010_0000, 4'b1111);
    cfg_wr(8'h70, 32'h0000_0004, 4'b1111);
    rd_chk("R6 legacy0 kept", 8'h50, 32'h0000_0004);
    rd_chk("R6 legacy1 kept", 8'h54, 32'h1000_0000);
    rd_chk("R6 mode kept blk zero", 8'h70, 32'h0000_0C00);
    chk("R6 irq kept", {31'b0, irq_o}, 32'h1);
    cfg_wr(8'h70, 32'hFFFF_FFFF, 4'b1111);
    rd_chk("R5 multi-lane clear", 8'h70, 32'h0);
    rd_chk("R11 legacy after multi", 8'h54, 32'h0);
  endtask

  task automatic t_block();
    drv_set(2'b00);
    drv_set(2'b01);
    chk("R8 ch0 open", {31'b0, irq_o}, 32'h1);
    mask_wr_en = 1'b1; mask_wr_data = 2'b01;
    #5;
    chk("R9 mask before edge", {31'b0, irq_o}, 32'h1);
    tick();
    mask_wr_en = 1'b0;
    chk("R8 ch0 blocked", {31'b0, irq_o}, 32'h0);
    rd_chk("R7 blk0 read", 8'h70, 32'h0000_1400);
    drv_set(2'b11);
    chk("R8 ch1 open", {31'b0, irq_o}, 32'h1);
    mask_set(2'b11);
    chk("R8 both blocked", {31'b0, irq_o}, 32'h0);
    cfg_wr(8'h70, 32'h0000_0000, 4'b1111);
    rd_chk("R7 R6 blk kept", 8'h70, 32'h0000_3C00);
    mask_set(2'b10);
    chk("R8 ch0 unblocked", {31'b0, irq_o}, 32'h1);
    mask_set(2'b00);
    cfg_wr(8'h70, 32'h0000_0C00, 4'b0010);
    chk("R8 cleared", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_race();
    drv_set(2'b00);
    drv_irq = 2'b01;
    cfg_wr(8'h50, 32'h0000_0004, 4'b0001);
    rd_chk("R10 ch0 drive wins", 8'h50, 32'h0000_0004);
    drv_irq = 2'b11;
    cfg_wr(8'h70, 32'h0000_0800, 4'b0010);
    rd_chk("R10 ch1 drive wins", 8'h70, 32'h0000_0C00);
    chk("R10 irq", {31'b0, irq_o}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; drv_irq = '0; cfg_wr_en = 1'b0; cfg_wr_addr = '0;
    cfg_wr_be = '0; cfg_wr_data = '0; cfg_rd_addr = '0;
    mask_wr_en = 1'b0; mask_wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_drive_rise();
    t_legacy_ack();
    t_drive_fall();
    t_mode_ack();
    t_no_effect();
    t_block();
    t_race();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule